// File: doc/BRIEF.md
# Parallel Device Bus Timing Controller

This block is the master side of an asynchronous external bus for flash, static RAM or programmable-logic devices. Address and data share one bus. An address-latch strobe marks the address phase. Active-low chip select, output enable and write enable frame each transfer. A separate 3-bit low address advances on every beat of a burst. Two 32-bit timing words set every phase length, counted in clock ticks. A plain write port loads the two words, and they must be loaded while the bus is idle.

The host asks for a transfer with a valid/ready handshake. A request carries the direction, a full address, a beat count minus one and the first write datum. On a burst write the block pulses `wdata_take` in the cycle it captures the next datum from `req_wdata`. Read beats come back on `rd_data` with a one-cycle `rd_valid` strobe, one cycle after the bus sample.

In the description below, "t0" means the first cycle after the address-latch cycle. Each phase is counted by its own tick counter, and those counters interact only in the fixed ways listed here.

Top module: `pbus_timing_ctrl`

## Requirements
- R1: A write with `cfg_addr`=0 loads the read timing word: turn-off in bits 5:0, first access in 11:6, read setup in 16:12, next access in 22:17 and read hold in 27:23. A write with `cfg_addr`=4 loads the write timing word: address-to-strobe in 7:0, strobe low in 15:8 and strobe high in 23:16. Writes to any other `cfg_addr` change nothing.
- R2: An accepted request gives exactly one `ale` cycle, in the cycle after acceptance. In that cycle `ad_oe`=1, `ad_out` holds the full request address, and `cs_n`, `oe_n` and `we_n` are high.
- R3: `cs_n` falls at t0. On a read, `oe_n` falls read-setup cycles after that, or at t0 when read setup is 0. It is never low while `cs_n` is high.
- R4: The first read sample is taken at t0 plus first access, whatever the read setup. `rd_valid` pulses in the next cycle with the value `ad_in` held in the sample cycle.
- R5: Later burst read samples follow each other by the next-access count, and a count of 0 acts as 1. `a_low` equals request address bits 2:0 plus the beat index, modulo 8.
- R6: `oe_n` rises in the cycle after the last sample. `cs_n` rises read-hold cycles after that, so with a hold of 0 both rise together.
- R7: The block never drives the bus while `oe_n` is low. After a read, `req_ready` stays low until the turn-off count has run from the cycle after the last sample and `cs_n` has risen. The next `ale` comes one cycle after both conditions hold.
- R8: `we_n` falls at t0 plus address-to-strobe and stays low for the strobe-low count, where 0 acts as 1. `ad_out` and `a_low` do not change while it is low.
- R9: Between burst write beats `we_n` stays high for the strobe-high count, where 0 acts as 1. The next datum and `a_low` appear only in the last high cycle. `wdata_take` pulses in the cycle before that.
- R10: On a write `oe_n` stays high and `ad_oe` stays high from `ale` to the end. `cs_n` rises in the cycle `we_n` rises after the last beat.
- R11: During and right after reset `cs_n`, `oe_n` and `we_n` are high, `ale`, `ad_oe` and `rd_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Timing word write strobe |
| cfg_addr | input | 3 | Timing word byte offset (0 read, 4 write) |
| cfg_wdata | input | 32 | Timing word value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Full transfer address |
| req_len | input | 3 | Beats minus one |
| req_wdata | input | 16 | Write datum (first beat at accept, later at take) |
| wdata_take | output | 1 | Next write datum captured at this edge |
| rd_data | output | 16 | Read beat data |
| rd_valid | output | 1 | Read beat valid pulse |
| ad_out | output | 16 | Address/data bus out |
| ad_oe | output | 1 | Bus drive enable |
| ad_in | input | 16 | Address/data bus in |
| ale | output | 1 | Address latch strobe |
| cs_n | output | 1 | Chip select, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| a_low | output | 3 | Beat address bits |

## Verification
Two events can land in the same cycle. The first is the end of the last read sample, which releases output enable and starts the turn-off count while chip-select hold is still running. The second is the end of a strobe-low period when the strobe-high count is 1, so that the next-datum capture takes place in the very cycle write enable rises. Both are provoked with back-to-back reads whose hold and turn-off counts are set on both sides of each other, and with a burst write whose counts are all 0. They are judged from the recorded cycle numbers of every edge on `cs_n`, `oe_n`, `we_n`, `ale` and `wdata_take`, compared with cycle numbers computed from the requirements.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    localparam int CNT_W   = 8;
    localparam int TOFF_W  = 6;
    localparam int LOW_AW  = 3;
    localparam int RD_OFF  = 0;
    localparam int WR_OFF  = 4;

    typedef struct packed {
        logic [5:0] turn_off;
        logic [5:0] first;
        logic [4:0] setup;
        logic [5:0] next;
        logic [4:0] hold;
    } rd_timing_t;

    typedef struct packed {
        logic [7:0] ale_to_we;
        logic [7:0] we_low;
        logic [7:0] we_high;
    } wr_timing_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ALE, ST_RFIRST, ST_RNEXT, ST_RHOLD,
        ST_WSETUP, ST_WLOW, ST_WHIGH
    } seq_state_t;

    function automatic logic [CNT_W-1:0] at_least_one(input logic [CNT_W-1:0] v);
        return (v == '0) ? CNT_W'(1) : v;
    endfunction

endpackage

// File: rtl/pbus_cfg_regs.sv
module pbus_cfg_regs
    import pbus_pkg::*;
#(
    parameter int CFG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output rd_timing_t        rd_t,
    output wr_timing_t        wr_t
);
    logic unused_fields;
    assign unused_fields = ^cfg_wdata[31:28];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_t <= '0;
            wr_t <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == CFG_AW'(RD_OFF)) begin
                rd_t.turn_off <= cfg_wdata[5:0];
                rd_t.first    <= cfg_wdata[11:6];
                rd_t.setup    <= cfg_wdata[16:12];
                rd_t.next     <= cfg_wdata[22:17];
                rd_t.hold     <= cfg_wdata[27:23];
            end
            if (cfg_addr == CFG_AW'(WR_OFF)) begin
                wr_t.ale_to_we <= cfg_wdata[7:0];
                wr_t.we_low    <= cfg_wdata[15:8];
                wr_t.we_high   <= cfg_wdata[23:16];
            end
        end
    end
endmodule

// File: rtl/pbus_turnoff.sv
module pbus_turnoff #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          quiet
);
    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)                remain <= '0;
        else if (load)          remain <= load_val;
        else if (remain != '0)  remain <= remain - TW'(1);
    end

    assign quiet = (remain == '0);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
    import pbus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_timing_t        rd_t,
    input  wr_timing_t        wr_t,
    input  logic              bus_quiet,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              wdata_take,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              last_sample,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [LOW_AW-1:0] a_low
);
    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  beat, len_q;
    logic [DATA_W-1:0] addr_q, wdata_q;
    logic              write_q;

    logic [CNT_W-1:0] first_c, setup_c, hold_c, alew_c;
    logic [CNT_W-1:0] next_eff, low_eff, high_eff;
    logic             more, sample, low_done, in_read, in_write;

    assign first_c  = CNT_W'(rd_t.first);
    assign setup_c  = CNT_W'(rd_t.setup);
    assign hold_c   = CNT_W'(rd_t.hold);
    assign alew_c   = wr_t.ale_to_we;
    assign next_eff = at_least_one(CNT_W'(rd_t.next));
    assign low_eff  = at_least_one(wr_t.we_low);
    assign high_eff = at_least_one(wr_t.we_high);

    assign more     = (beat != len_q);
    assign sample   = (state == ST_RFIRST && cnt == first_c) ||
                      (state == ST_RNEXT  && cnt == next_eff - CNT_W'(1));
    assign low_done = (state == ST_WLOW && cnt == low_eff - CNT_W'(1));
    assign wdata_take = (low_done && more && high_eff == CNT_W'(1)) ||
                        (state == ST_WHIGH && high_eff >= CNT_W'(2) &&
                         cnt == high_eff - CNT_W'(2));
    assign last_sample = sample && !more;

    assign in_read  = (state == ST_RFIRST) || (state == ST_RNEXT) || (state == ST_RHOLD);
    assign in_write = (state == ST_WSETUP) || (state == ST_WLOW) || (state == ST_WHIGH);

    assign req_ready = (state == ST_IDLE) && bus_quiet;
    assign ale       = (state == ST_ALE);
    assign cs_n      = !(in_read || in_write);
    assign oe_n      = !((state == ST_RFIRST && cnt >= setup_c) || state == ST_RNEXT);
    assign we_n      = !(state == ST_WLOW);
    assign ad_oe     = ale || in_write;
    assign ad_out    = ale ? addr_q : wdata_q;
    assign a_low     = addr_q[LOW_AW-1:0] + LOW_AW'(beat);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            beat     <= '0;
            len_q    <= '0;
            addr_q   <= '0;
            wdata_q  <= '0;
            write_q  <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= sample;
            if (sample) rd_data <= ad_in;
            if (wdata_take) begin
                wdata_q <= req_wdata;
                beat    <= beat + LEN_W'(1);
            end
            cnt <= cnt + CNT_W'(1);
            case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (req_valid && req_ready) begin
                        state   <= ST_ALE;
                        addr_q  <= req_addr;
                        len_q   <= req_len;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        beat    <= '0;
                    end
                end
                ST_ALE: begin
                    cnt <= '0;
                    if (!write_q)            state <= ST_RFIRST;
                    else if (alew_c == '0)   state <= ST_WLOW;
                    else                     state <= ST_WSETUP;
                end
                ST_RFIRST, ST_RNEXT: begin
                    if (sample) begin
                        cnt <= '0;
                        if (more) begin
                            beat  <= beat + LEN_W'(1);
                            state <= ST_RNEXT;
                        end else begin
                            state <= (hold_c == '0) ? ST_IDLE : ST_RHOLD;
                        end
                    end
                end
                ST_RHOLD: begin
                    if (cnt == hold_c - CNT_W'(1)) begin
                        cnt   <= '0;
                        state <= ST_IDLE;
                    end
                end
                ST_WSETUP: begin
                    if (cnt == alew_c - CNT_W'(1)) begin
                        cnt   <= '0;
                        state <= ST_WLOW;
                    end
                end
                ST_WLOW: begin
                    if (low_done) begin
                        cnt   <= '0;
                        state <= more ? ST_WHIGH : ST_IDLE;
                    end
                end
                ST_WHIGH: begin
                    if (cnt == high_eff - CNT_W'(1)) begin
                        cnt   <= '0;
                        state <= ST_WLOW;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pbus_timing_ctrl.sv
module pbus_timing_ctrl
    import pbus_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LEN_W  = 3,
    parameter int CFG_AW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              wdata_take,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              cs_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [2:0]        a_low
);
    rd_timing_t rd_t;
    wr_timing_t wr_t;
    logic       bus_quiet, last_sample;

    pbus_cfg_regs #(.CFG_AW(CFG_AW)) u_cfg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_t(rd_t), .wr_t(wr_t)
    );

    pbus_turnoff #(.TW(TOFF_W)) u_toff (
        .clk(clk), .rst(rst), .load(last_sample),
        .load_val(rd_t.turn_off), .quiet(bus_quiet)
    );

    pbus_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst), .rd_t(rd_t), .wr_t(wr_t), .bus_quiet(bus_quiet),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .wdata_take(wdata_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .last_sample(last_sample), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .ale(ale), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .a_low(a_low)
    );
endmodule

// File: rtl/pbus_timing_chk.sv
module pbus_timing_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              ale,
    input logic              cs_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              ad_oe,
    input logic [DATA_W-1:0] ad_out,
    input logic [2:0]        a_low,
    input logic              req_ready
);
    p_ale_single_r2: assert property (@(posedge clk) disable iff (rst)
        ale |=> !ale);

    p_ale_phase_r2: assert property (@(posedge clk) disable iff (rst)
        ale |-> (ad_oe && cs_n && oe_n && we_n));

    p_oe_inside_cs_r3: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !cs_n);

    p_no_drive_read_r7: assert property (@(posedge clk) disable iff (rst)
        !oe_n |-> !ad_oe);

    p_ready_bus_free_r7: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (cs_n && !ad_oe));

    p_we_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!we_n && $past(!we_n)) |-> ($stable(ad_out) && $stable(a_low)));

    p_we_oe_apart_r10: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> oe_n);
endmodule

bind pbus_timing_ctrl pbus_timing_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ale(ale), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .ad_oe(ad_oe), .ad_out(ad_out), .a_low(a_low), .req_ready(req_ready)
);

// File: tb/test_pbus_timing_ctrl.sv
module test_pbus_timing_ctrl;
    logic        clk = 0, rst = 1;
    logic        cfg_we = 0;
    logic [2:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic        req_valid = 0, req_ready, req_write = 0;
    logic [15:0] req_addr = 0, req_wdata;
    logic [2:0]  req_len = 0;
    logic        wdata_take, rd_valid, ad_oe, ale, cs_n, oe_n, we_n;
    logic [15:0] rd_data, ad_out, ad_in;
    logic [2:0]  a_low;
    logic [31:0] cyc = 0;
    logic [3:0]  wr_idx = 0;
    logic [11:0] wtag = 12'h5A3;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    pbus_timing_ctrl i_pbus_timing_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
        .wdata_take(wdata_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale),
        .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .a_low(a_low)
    );

    // device model: returns the current cycle tag and beat address
    assign ad_in     = {cyc[7:0], 5'd0, a_low};
    assign req_wdata = {wtag, wr_idx};

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (req_valid && req_ready)  wr_idx <= 4'd1;
        else if (wdata_take)         wr_idx <= wr_idx + 4'd1;
        else if (!req_valid && req_ready) wr_idx <= 4'd0;
    end

    // edge recorder
    int ale_c[8], ale_d[8], ale_ok[8], cs_f[8], cs_r[8], oe_f[8], oe_r[8];
    int we_f[8], we_r[8], we_d[8], we_a[8], rv_c[8], rv_d[8], tk_c[8];
    int n_ale, n_csf, n_csr, n_oef, n_oer, n_wef, n_wer, n_rv, n_tk, n_oe_wr;
    logic p_cs = 1, p_oe = 1, p_we = 1;

    task automatic clear_mon();
        n_ale = 0; n_csf = 0; n_csr = 0; n_oef = 0; n_oer = 0;
        n_wef = 0; n_wer = 0; n_rv = 0; n_tk = 0; n_oe_wr = 0;
    endtask

    always @(negedge clk) if (!rst) begin
        if (ale && n_ale < 8) begin
            ale_c[n_ale] = cyc; ale_d[n_ale] = ad_out;
            ale_ok[n_ale] = (ad_oe && cs_n && oe_n && we_n) ? 1 : 0; n_ale++;
        end
        if (!cs_n && p_cs && n_csf < 8) begin cs_f[n_csf] = cyc; n_csf++; end
        if (cs_n && !p_cs && n_csr < 8) begin cs_r[n_csr] = cyc; n_csr++; end
        if (!oe_n && p_oe && n_oef < 8) begin oe_f[n_oef] = cyc; n_oef++; end
        if (oe_n && !p_oe && n_oer < 8) begin oe_r[n_oer] = cyc; n_oer++; end
        if (!we_n && p_we && n_wef < 8) begin
            we_f[n_wef] = cyc; we_d[n_wef] = ad_out; we_a[n_wef] = a_low; n_wef++;
        end
        if (we_n && !p_we && n_wer < 8) begin we_r[n_wer] = cyc; n_wer++; end
        if (rd_valid && n_rv < 8) begin rv_c[n_rv] = cyc; rv_d[n_rv] = rd_data; n_rv++; end
        if (wdata_take && n_tk < 8) begin tk_c[n_tk] = cyc; n_tk++; end
        if (!cs_n && !we_n && !oe_n) n_oe_wr++;
        p_cs = cs_n; p_oe = oe_n; p_we = we_n;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    function automatic logic [31:0] rd_word(int toff, int first, int setup, int nxt, int hold);
        return 32'(toff) | (32'(first) << 6) | (32'(setup) << 12) |
               (32'(nxt) << 17) | (32'(hold) << 23);
    endfunction

    function automatic logic [31:0] wr_word(int alew, int low, int high);
        return 32'(alew) | (32'(low) << 8) | (32'(high) << 16);
    endfunction

    function automatic int rd_exp(int s, int al);
        return int'({8'(s), 5'd0, 3'(al)});
    endfunction

    task automatic send(input logic wr, input logic [15:0] addr, input logic [2:0] len);
        @(negedge clk); req_write = wr; req_addr = addr; req_len = len; req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk); req_valid = 0;
    endtask

    task automatic wait_cs(input int n);
        int k = 0;
        while (n_csr < n && k < 500) begin @(negedge clk); k++; end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R11 cs_n", cs_n, 1); check("R11 oe_n", oe_n, 1);
        check("R11 we_n", we_n, 1); check("R11 ale", ale, 0);
        check("R11 ad_oe", ad_oe, 0); check("R11 rd_valid", rd_valid, 0);
        check("R11 req_ready", req_ready, 1);
    endtask

    task automatic t_burst_read();
        int l;
        cfg_write(3'd0, rd_word(5, 4, 2, 3, 1));
        clear_mon(); send(0, 16'h1236, 3'd3); wait_cs(1);
        l = ale_c[0];
        check("R2 ale count", n_ale, 1);
        check("R2 ale address", ale_d[0], 16'h1236);
        check("R2 ale phase", ale_ok[0], 1);
        check("R3 cs fall", cs_f[0], l + 1);
        check("R1 R3 oe fall after setup", oe_f[0], l + 3);
        check("R5 beats", n_rv, 4);
        for (int k = 0; k < 4; k++) begin
            check("R1 R4 R5 sample cycle", rv_c[k], l + 6 + 3 * k);
            check("R4 R5 sample data", rv_d[k], rd_exp(l + 5 + 3 * k, 6 + k));
        end
        check("R6 oe rise", oe_r[0], l + 15);
        check("R1 R6 cs rise after hold", cs_r[0], l + 16);
    endtask

    task automatic t_zero_read();
        int l;
        cfg_write(3'd0, rd_word(0, 0, 0, 0, 0));
        cfg_write(3'd2, rd_word(9, 9, 9, 9, 9));
        cfg_write(3'd6, 32'hFFFF_FFFF);
        clear_mon(); send(0, 16'h0003, 3'd0); wait_cs(1);
        l = ale_c[0];
        check("R1 R3 cs and oe fall together", oe_f[0], cs_f[0]);
        check("R4 zero first sample", rv_c[0], l + 2);
        check("R4 zero data", rv_d[0], rd_exp(l + 1, 3));
        check("R1 R6 oe and cs rise together", cs_r[0], oe_r[0]);
        check("R6 oe rise", oe_r[0], l + 2);
    endtask

    task automatic t_setup_indep();
        int l;
        cfg_write(3'd0, rd_word(0, 3, 3, 0, 0));
        clear_mon(); send(0, 16'h00F0, 3'd1); wait_cs(1);
        l = ale_c[0];
        check("R3 late oe", oe_f[0], l + 4);
        check("R4 first sample unaffected by setup", rv_c[0], l + 5);
        check("R5 next zero acts as one", rv_c[1], l + 6);
        check("R5 a_low step", rv_d[1], rd_exp(l + 5, 1));
    endtask

    task automatic t_turnoff(input int toff, input int hold, input int exp_gap);
        cfg_write(3'd0, rd_word(toff, 1, 0, 0, hold));
        clear_mon();
        @(negedge clk); req_write = 0; req_addr = 16'h0010; req_len = 0; req_valid = 1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        @(negedge clk); req_valid = 0;
        wait_cs(2);
        check("R7 second ale after turn-off and hold", ale_c[1] - ale_c[0], exp_gap);
        check("R6 cs rise with hold", cs_r[0], ale_c[0] + 3 + hold);
    endtask

    task automatic t_burst_write();
        int l;
        cfg_write(3'd4, wr_word(2, 3, 2));
        wtag = 12'h5A3;
        clear_mon(); send(1, 16'h4445, 3'd2); wait_cs(1);
        l = ale_c[0];
        check("R2 write ale address", ale_d[0], 16'h4445);
        check("R10 cs fall", cs_f[0], l + 1);
        check("R8 beats", n_wef, 3);
        for (int k = 0; k < 3; k++) begin
            check("R1 R8 we fall", we_f[k], l + 3 + 5 * k);
            check("R8 we low length", we_r[k] - we_f[k], 3);
            check("R8 write data", we_d[k], int'({12'h5A3, 4'(k)}));
            check("R8 a_low", we_a[k], (5 + k) % 8);
        end
        check("R9 take count", n_tk, 2);
        check("R9 take before final high", tk_c[0], we_r[0]);
        check("R9 take before final high", tk_c[1], we_r[1]);
        check("R10 cs rise at last we rise", cs_r[0], we_r[2]);
        check("R10 no oe on write", n_oef, 0);
    endtask

    task automatic t_zero_write();
        int l;
        cfg_write(3'd4, wr_word(0, 0, 0));
        wtag = 12'h0C7;
        clear_mon(); send(1, 16'h0007, 3'd1); wait_cs(1);
        l = ale_c[0];
        check("R8 zero counts we fall", we_f[0], l + 1);
        check("R9 high zero acts as one", we_f[1], l + 3);
        check("R9 take in last low cycle", tk_c[0], l + 1);
        check("R9 second datum", we_d[1], int'({12'h0C7, 4'd1}));
        check("R9 a_low wraps", we_a[1], 0);
        check("R10 cs rise", cs_r[0], l + 4);
        check("R10 no oe", n_oe_wr, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        clear_mon();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 in reset ready", req_ready, 1);
        check("R11 in reset cs_n", cs_n, 1);
        rst = 0;
        t_reset();
        t_burst_read();
        t_zero_read();
        t_setup_indep();
        t_turnoff(6, 2, 10);
        t_turnoff(1, 4, 8);
        t_burst_write();
        t_zero_write();
        summary();
        $finish;
    end
endmodule